// File: doc/BRIEF.md
# Flash Reset and Ready/Busy Sequencer

This block sits between the reset pin of a parallel NOR flash model and its program/erase engine. It samples the active-low reset pin as a digital level and times how long the pin stays low. A pulse that is too short is ignored. A pulse that is long enough starts a reset sequence. While the sequence runs, the block masks commands, drops the device-available flag, and runs a recovery period after the pin is released.

The length of the recovery depends on the engine's status when the pin first went low. From read or standby the recovery is short and the ready/busy flag stays high. From program, erase or erase-suspend the recovery is long. In that case a one-cycle abort pulse goes to the engine, the ready/busy flag is held low through the whole recovery, and its rising edge marks the end. Outside a reset sequence the block decodes ready/busy from the engine status and gates commands: a busy engine takes only the erase-suspend command.

The controller has four states:
- RUN: normal operation.
- PEND: the pin is low but the pulse has not yet qualified.
- HOLD: a qualified reset is in progress and the pin is still low.
- RECOVER: the pin has been released and the recovery timer runs.

Transitions:
- RUN→PEND: the pin is sampled low. The recovery mode is latched at this transition.
- PEND→RUN: the pin is released before the pulse qualifies.
- PEND→HOLD: the pulse qualifies. The abort pulse is issued here, in long mode only.
- HOLD→RECOVER: the pin is sampled high.
- RECOVER→HOLD: the pin goes low again during recovery.
- RECOVER→RUN: the timer expires.

Top module: `flash_rst_rdy_seq`

## Requirements
- R1: After system reset, with the engine idle and the pin high: `rb_n`=1, `rst_active`=0, `dev_avail`=1 and `pe_abort`=0.
- R2: Outside a reset sequence, `rb_n` is 0 exactly when `pe_busy`=1, `pe_suspended`=0 and `pe_standby`=0; otherwise it is 1.
- R3: Outside a reset sequence, `cmd_grant` = `cmd_req` while the engine is not active in the R2 sense. While the engine is active, only a request with `cmd_is_suspend`=1 is granted.
- R4: A pin low for fewer than RST_MIN cycles (pulse width / clock period, rounded up) of consecutive rising-edge samples is ignored: `rst_active`, `dev_avail` and `pe_abort` do not change.
- R5: A pin low for RST_MIN consecutive samples is accepted. `rst_active`=1 and `dev_avail`=0 appear after the (RST_MIN+1)-th rising edge counted from the first edge that samples the pin low.
- R6: Short mode is latched when, at the first low sample, `pe_busy` and `pe_suspended` are both 0 or `pe_standby`=1. In short mode `rb_n` stays 1 through the reset. `dev_avail` returns to 1 on the (REC_SHORT+2)-th rising edge after the pin is released, and not before.
- R7: Long mode is latched otherwise. `rb_n` is held 0 from acceptance until the end of recovery, and rises on the same edge as `dev_avail`: the (REC_LONG+2)-th rising edge after release.
- R8: In long mode `pe_abort` is high for exactly one cycle: the cycle ending at the (RST_MIN+1)-th edge. In short mode it stays 0.
- R9: A low pin during RECOVER restarts recovery from zero at the next release. The mode latched by the first reset is kept, whatever the engine status is by then, and no second abort is issued.
- R10: While `rst_active`=1, `cmd_grant` is 0 for every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| rp_n | input | 1 | Device reset pin level, active low |
| pe_busy | input | 1 | Engine has a program or erase operation in progress |
| pe_suspended | input | 1 | Engine is in erase-suspend |
| pe_standby | input | 1 | Device is in standby |
| cmd_req | input | 1 | Program/erase command request |
| cmd_is_suspend | input | 1 | The requested command is erase-suspend |
| rb_n | output | 1 | Ready/busy flag, low means busy |
| rst_active | output | 1 | A qualified reset is active or recovering |
| dev_avail | output | 1 | Device accepts new operations |
| pe_abort | output | 1 | One-cycle abort request to the engine |
| cmd_grant | output | 1 | Command accepted |

## Verification
The bench uses the default parameters, a 10 ns clock period with limits of 500 ns, 50 ns and 10 µs. These give cycle limits of 50, 5 and 1000. Pulses of 49 and 50 cycles probe the acceptance boundary exactly. The short recovery is short enough to check its end edge by edge, and the full 1000-cycle long recovery, including a restart in the middle of recovery, fits easily within the run time.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_PEND,
        ST_HOLD,
        ST_RECOVER
    } frs_state_t;

    typedef enum logic {
        MODE_SHORT,
        MODE_LONG
    } frs_mode_t;

    // nanoseconds to whole clock cycles, rounded up
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/frs_pin_qualifier.sv
module frs_pin_qualifier #(
    parameter int MIN_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_q,
    output logic qual
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYC - 1);

    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   <= 1'b1;
            low_cnt <= '0;
        end else begin
            pin_q <= pin_n;
            if (pin_q) begin
                low_cnt <= '0;
            end else if (low_cnt != LAST) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    assign qual = !pin_q && (low_cnt == LAST);

    // qualification can only follow a low sample in the previous cycle
    AST_QUAL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> $past(!pin_q)); // R4

endmodule

// File: rtl/frs_recovery_timer.sv
module frs_recovery_timer #(
    parameter int SHORT_CYC = 5,
    parameter int LONG_CYC  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mode_long,
    output logic done
);
    localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] SHORT_LAST = TW'(SHORT_CYC - 1);
    localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_CYC - 1);

    logic [TW-1:0] tcnt;
    logic [TW-1:0] limit;

    assign limit = mode_long ? LONG_LAST : SHORT_LAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (!run) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    assign done = run && (tcnt == limit);

    // the counter never runs past the limit of the latched mode
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tcnt <= limit)); // R7

    // a running timer only ever advances by one or restarts
    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(done)) |-> (tcnt == $past(tcnt) + 1'b1)); // R9

endmodule

// File: rtl/frs_seq_fsm.sv
module frs_seq_fsm
    import frs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_q,
    input  logic qual,
    input  logic rec_done,
    input  logic pe_busy,
    input  logic pe_suspended,
    input  logic pe_standby,
    input  logic cmd_req,
    input  logic cmd_is_suspend,
    output logic rec_run,
    output logic mode_long,
    output logic rb_n,
    output logic rst_active,
    output logic dev_avail,
    output logic pe_abort,
    output logic cmd_grant
);
    frs_state_t state, nxt;
    frs_mode_t  mode;
    logic       eng_active;
    logic       long_now;

    assign eng_active = pe_busy && !pe_suspended && !pe_standby;
    assign long_now   = (pe_busy || pe_suspended) && !pe_standby;

    // state register and mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            mode  <= MODE_SHORT;
        end else begin
            state <= nxt;
            if (state == ST_RUN && !pin_q) begin
                mode <= long_now ? MODE_LONG : MODE_SHORT;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:     if (!pin_q) nxt = ST_PEND;
            ST_PEND:    if (pin_q) nxt = ST_RUN;
                        else if (qual) nxt = ST_HOLD;
            ST_HOLD:    if (pin_q) nxt = ST_RECOVER;
            ST_RECOVER: if (!pin_q) nxt = ST_HOLD;
                        else if (rec_done) nxt = ST_RUN;
            default:    nxt = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        rb_n       = 1'b1;
        rst_active = 1'b0;
        dev_avail  = 1'b1;
        pe_abort   = 1'b0;
        rec_run    = 1'b0;
        unique case (state)
            ST_RUN: begin
                rb_n = !eng_active;
            end
            ST_PEND: begin
                rb_n     = !eng_active;
                pe_abort = qual && !pin_q && (mode == MODE_LONG);
            end
            ST_HOLD: begin
                rst_active = 1'b1;
                dev_avail  = 1'b0;
                rb_n       = (mode != MODE_LONG);
            end
            ST_RECOVER: begin
                rst_active = 1'b1;
                dev_avail  = 1'b0;
                rb_n       = (mode != MODE_LONG);
                rec_run    = 1'b1;
            end
            default: begin
                rb_n = 1'b1;
            end
        endcase
        cmd_grant = cmd_req && dev_avail && (!eng_active || cmd_is_suspend);
    end

    assign mode_long = (mode == MODE_LONG);

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pe_abort |=> !pe_abort); // R8

    AST_ABORT_ENTERS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        pe_abort |=> (rst_active && !rb_n)); // R7

    AST_NO_GRANT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |-> !cmd_grant); // R10

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && $past(state != ST_RUN)) |-> $stable(mode)); // R9

    AST_RELEASE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active) |-> pin_q); // R6

    AST_BUSY_RISE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rb_n) && $past(rst_active)) |-> !rst_active); // R7

endmodule

// File: rtl/flash_rst_rdy_seq.sv
module flash_rst_rdy_seq
    import frs_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int RST_MIN_NS    = 500,
    parameter int REC_SHORT_NS  = 50,
    parameter int REC_LONG_NS   = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rp_n,
    input  logic pe_busy,
    input  logic pe_suspended,
    input  logic pe_standby,
    input  logic cmd_req,
    input  logic cmd_is_suspend,
    output logic rb_n,
    output logic rst_active,
    output logic dev_avail,
    output logic pe_abort,
    output logic cmd_grant
);
    localparam int RST_MIN_CYC   = ns_to_cycles(RST_MIN_NS, CLK_PERIOD_NS);
    localparam int REC_SHORT_CYC = ns_to_cycles(REC_SHORT_NS, CLK_PERIOD_NS);
    localparam int REC_LONG_CYC  = ns_to_cycles(REC_LONG_NS, CLK_PERIOD_NS);

    initial begin
        AST_PARAM_RANGE: assert (RST_MIN_CYC >= 2 && REC_SHORT_CYC >= 1
                                 && REC_LONG_CYC >= 1); // R5
    end

    logic pin_q;
    logic qual;
    logic rec_run;
    logic rec_done;
    logic mode_long;

    frs_pin_qualifier #(
        .MIN_CYC (RST_MIN_CYC)
    ) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (rp_n),
        .pin_q (pin_q),
        .qual  (qual)
    );

    frs_recovery_timer #(
        .SHORT_CYC (REC_SHORT_CYC),
        .LONG_CYC  (REC_LONG_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (rec_run),
        .mode_long (mode_long),
        .done      (rec_done)
    );

    frs_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_q          (pin_q),
        .qual           (qual),
        .rec_done       (rec_done),
        .pe_busy        (pe_busy),
        .pe_suspended   (pe_suspended),
        .pe_standby     (pe_standby),
        .cmd_req        (cmd_req),
        .cmd_is_suspend (cmd_is_suspend),
        .rec_run        (rec_run),
        .mode_long      (mode_long),
        .rb_n           (rb_n),
        .rst_active     (rst_active),
        .dev_avail      (dev_avail),
        .pe_abort       (pe_abort),
        .cmd_grant      (cmd_grant)
    );

endmodule

// File: tb/test_flash_rst_rdy_seq.sv
module test_flash_rst_rdy_seq;

    localparam int MIN_C   = 50;    // 500 ns / 10 ns
    localparam int SHORT_C = 5;     // 50 ns / 10 ns
    localparam int LONG_C  = 1000;  // 10 us / 10 ns

    // {busy, suspended, standby, req, is_suspend, exp_rb_n, exp_grant}
    localparam logic [6:0] VEC [8] = '{
        7'b00010_11,
        7'b00000_10,
        7'b10010_00,
        7'b10011_01,
        7'b11010_11,
        7'b01010_11,
        7'b00110_11,
        7'b10100_10
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rp_n = 1'b1;
    logic pe_busy = 1'b0;
    logic pe_suspended = 1'b0;
    logic pe_standby = 1'b0;
    logic cmd_req = 1'b0;
    logic cmd_is_suspend = 1'b0;
    logic rb_n, rst_active, dev_avail, pe_abort, cmd_grant;

    int checks = 0;
    int fails = 0;
    int aborts = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_rst_rdy_seq i_flash_rst_rdy_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .rp_n           (rp_n),
        .pe_busy        (pe_busy),
        .pe_suspended   (pe_suspended),
        .pe_standby     (pe_standby),
        .cmd_req        (cmd_req),
        .cmd_is_suspend (cmd_is_suspend),
        .rb_n           (rb_n),
        .rst_active     (rst_active),
        .dev_avail      (dev_avail),
        .pe_abort       (pe_abort),
        .cmd_grant      (cmd_grant)
    );

    always @(posedge clk) if (rst_n && pe_abort) aborts++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int a0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 rb_n", rb_n, 1);
        chk("R1 rst_active", rst_active, 0);
        chk("R1 dev_avail", dev_avail, 1);
        chk("R1 pe_abort", pe_abort, 0);

        // R2 / R3 table
        foreach (VEC[i]) begin
            {pe_busy, pe_suspended, pe_standby, cmd_req, cmd_is_suspend} = VEC[i][6:2];
            #1;
            chk("R2 rb_n", rb_n, VEC[i][1]);
            chk("R3 cmd_grant", cmd_grant, VEC[i][0]);
            tick(1);
        end
        {pe_busy, pe_suspended, pe_standby, cmd_req, cmd_is_suspend} = '0;
        tick(1);

        // R4: pulse one cycle short of the limit, engine busy
        pe_busy = 1'b1;
        a0 = aborts;
        rp_n = 1'b0;
        for (int k = 0; k < MIN_C - 1; k++) begin
            tick(1);
            if (rst_active || !dev_avail) chk("R4 ignored during pulse", rst_active, 0);
        end
        rp_n = 1'b1;
        tick(5);
        chk("R4 rst_active", rst_active, 0);
        chk("R4 dev_avail", dev_avail, 1);
        chk("R4 no abort", aborts - a0, 0);
        pe_busy = 1'b0;
        tick(1);

        // R5/R6: exact-limit pulse in short mode
        a0 = aborts;
        rp_n = 1'b0;
        tick(MIN_C);
        chk("R8 no abort in short mode", pe_abort, 0);
        chk("R5 not yet active", rst_active, 0);
        rp_n = 1'b1;
        tick(1);
        chk("R5 rst_active", rst_active, 1);
        chk("R5 dev_avail", dev_avail, 0);
        chk("R6 rb_n high", rb_n, 1);
        cmd_req = 1'b1;
        #1;
        chk("R10 masked", cmd_grant, 0);
        cmd_req = 1'b0;
        tick(SHORT_C);
        chk("R6 still recovering", dev_avail, 0);
        tick(1);
        chk("R6 available", dev_avail, 1);
        chk("R6 rst_active", rst_active, 0);
        chk("R8 short count", aborts - a0, 0);

        // R7/R8: long mode from program
        pe_busy = 1'b1;
        a0 = aborts;
        rp_n = 1'b0;
        tick(MIN_C);
        chk("R8 abort pulse", pe_abort, 1);
        rp_n = 1'b1;
        pe_busy = 1'b0;
        tick(1);
        chk("R8 abort dropped", pe_abort, 0);
        chk("R7 rb_n low", rb_n, 0);
        tick(LONG_C);
        chk("R7 rb_n still low", rb_n, 0);
        chk("R7 still unavailable", dev_avail, 0);
        tick(1);
        chk("R7 rb_n rises", rb_n, 1);
        chk("R7 available", dev_avail, 1);
        chk("R8 one abort", aborts - a0, 1);

        // R9: restart during recovery, mode from erase-suspend kept
        pe_suspended = 1'b1;
        a0 = aborts;
        rp_n = 1'b0;
        tick(MIN_C);
        rp_n = 1'b1;
        pe_suspended = 1'b0;
        tick(300);
        rp_n = 1'b0;
        tick(3);
        rp_n = 1'b1;
        tick(LONG_C + 1);
        chk("R9 recovery restarted", rst_active, 1);
        chk("R9 long mode kept", rb_n, 0);
        cmd_req = 1'b1;
        #1;
        chk("R10 masked in restart", cmd_grant, 0);
        cmd_req = 1'b0;
        tick(1);
        chk("R9 end of recovery", dev_avail, 1);
        chk("R9 rb_n high", rb_n, 1);
        chk("R9 single abort", aborts - a0, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule